// File: doc/BRIEF.md
# Tagged Fully Associative Translation Cache

This block caches translations from virtual page numbers to physical frame numbers for one fixed page size. A lookup compares the page number of the request against every entry at once and returns, one clock later, exactly one of three outcomes: a hit carrying the translated physical address, a miss, or a permission abort. Every entry carries an address-space tag and a global flag, so translations belonging to several processes can stay resident together. The entry's protection fields are checked against the access type and privilege level as part of the same lookup.

New translations arrive on a refill port. A refill whose page and tag are already resident rewrites that entry in place. Otherwise a victim is chosen, either by a rotating pointer or by a free-running shift-register sequence, and entries marked locked are never chosen. A maintenance port drops all entries of one address space, or every unlocked entry at once.

Top module: `tagged_tlb`

## Requirements
- R1: A lookup presented with `lk_valid` high returns its result on the next rising edge. `lk_done` is high in that cycle and exactly one of `lk_hit`, `lk_miss` and `lk_abort` is high. With no lookup, all four are low.
- R2: Every one of the DEPTH entries is searched on each lookup. On a hit, `lk_paddr` is the entry's frame number followed by the low PAGE_W bits of `lk_vaddr`. On a miss or an abort, `lk_paddr` is zero.
- R3: A non-global entry matches only when its stored tag equals `lk_asid`. A global entry matches whatever the value of `lk_asid`.
- R4: Permission codes for `rf_perm`: 0 means no access; 1 means privileged read/write only; 2 means privileged read/write with user read-only; 3 means read/write for both. `lk_kind` is 0 for fetch, 1 for read and 2 for write, and 3 is treated as a read. `lk_user`=1 marks a user access. A match becomes an abort when the code is 0, when a user access meets code 1, when a user write meets code 2, or when a fetch meets an entry whose `rf_xn` bit was set.
- R5: With `cfg_random`=0, the victim is the first unlocked entry at or after a rotating pointer, counting circularly. The pointer starts at entry 0 after reset and moves to the entry just after each victim. A refill that rewrites a resident entry leaves the pointer where it is.
- R6: With `cfg_random`=1, the search starts from the value of a free-running pseudo-random sequence instead of the pointer. Resident entries are then evicted in a scattered order rather than in a fixed rotation.
- R7: A locked entry is never chosen as a victim. If every entry is locked, a refill that matches no resident entry is discarded.
- R8: A refill that matches a resident entry is written over that entry. A match needs the same page and the same global flag, and for non-global entries the same tag. All fields are replaced, including the lock bit, and no second copy is created.
- R9: `inv_asid_en` clears every non-global entry whose tag equals `inv_asid`, whether or not it is locked. Global entries and entries with other tags are left intact.
- R10: `inv_all` clears every unlocked entry. Locked entries stay valid.
- R11: A refill is ignored in any cycle in which either invalidation is requested. A lookup in the same cycle as a refill sees the contents from before that refill.
- R12: After a synchronous active-low reset, every entry is invalid, the pointer is at entry 0, and all result outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_random | input | 1 | 1 selects pseudo-random victim choice, 0 selects the rotating pointer |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_kind | input | 2 | Access type: 0 fetch, 1 read, 2 write |
| lk_user | input | 1 | 1 for a user-level access |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VA_W-PAGE_W | Page number of the new entry |
| rf_asid | input | ASID_W | Tag of the new entry |
| rf_global | input | 1 | New entry matches every tag |
| rf_pfn | input | PA_W-PAGE_W | Frame number of the new entry |
| rf_perm | input | 2 | Permission code (see R4) |
| rf_xn | input | 1 | Fetches from this page abort |
| rf_lock | input | 1 | Protect the new entry from eviction |
| inv_all | input | 1 | Clear every unlocked entry |
| inv_asid_en | input | 1 | Clear the non-global entries of one tag |
| inv_asid | input | ASID_W | Tag to clear |
| lk_done | output | 1 | Lookup result present |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No entry matched |
| lk_abort | output | 1 | An entry matched but denied the access |
| lk_paddr | output | PA_W | Translated physical address |

## Verification
Entries can be observed only through lookups, so a wrong tag, flag or lock bit stays hidden until a later lookup or eviction touches it. The bench keeps its own model of every entry and of the rotating pointer and compares all outputs on every clock. A victim chosen in the wrong place, or an entry that survives an invalidation it should not have survived, therefore shows up at the first later lookup of the affected page. In random mode the exact victim cannot be predicted, so the bench checks only that locked entries survive and that the eviction order departs from plain rotation.

// File: rtl/tlb_pkg.sv
// Shared encodings for the translation cache: access kinds and permission codes.
// Assumes a 2-bit access-kind field and a 2-bit permission field at the top level.
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PERM_NONE    = 2'd0,
        PERM_PRIV    = 2'd1,
        PERM_USER_RO = 2'd2,
        PERM_FULL    = 2'd3
    } perm_e;

    localparam logic [15:0] LFSR_TAPS = 16'hB400;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/tlb_perm_check.sv
// Combinational protection check for one matched entry.
// Assumes the caller has already selected the matching entry; allow is meaningless otherwise.
module tlb_perm_check
    import tlb_pkg::*;
(
    input  perm_e     perm,
    input  logic      xn,
    input  acc_kind_e kind,
    input  logic      user,
    output logic      allow
);

    // Decide whether the access type and privilege fit the stored protection.
    always_comb begin
        allow = 1'b1;
        unique case (perm)
            PERM_NONE:    allow = 1'b0;
            PERM_PRIV:    if (user) allow = 1'b0;
            PERM_USER_RO: if (user && kind == ACC_WRITE) allow = 1'b0;
            PERM_FULL:    allow = 1'b1;
            default:      allow = 1'b0;
        endcase
        if (kind == ACC_FETCH && xn) allow = 1'b0;
    end

endmodule

// File: rtl/tlb_entry_array.sv
// Entry storage with two parallel compare ports: one for lookups, one that finds a
// resident duplicate of a refill. Handles writes and both invalidation kinds.
// Assumes the caller never raises wr_en in a cycle with an invalidation.
module tlb_entry_array #(
    parameter int DEPTH  = 32,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASID_W-1:0] look_asid,
    output logic              look_match,
    output logic [PFN_W-1:0]  look_pfn,
    output logic [1:0]        look_perm,
    output logic              look_xn,
    input  logic [VPN_W-1:0]  probe_vpn,
    input  logic [ASID_W-1:0] probe_asid,
    input  logic              probe_glob,
    output logic              dup_match,
    output logic [IDX_W-1:0]  dup_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [1:0]        wr_perm,
    input  logic              wr_xn,
    input  logic              wr_lock,
    input  logic              inv_all,
    input  logic              inv_tag_en,
    input  logic [ASID_W-1:0] inv_tag,
    output logic [DEPTH-1:0]  lock_vec
);

    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  lock_q;
    logic [DEPTH-1:0]  glob_q;
    logic [DEPTH-1:0]  xn_q;
    logic [VPN_W-1:0]  vpn_q  [DEPTH];
    logic [ASID_W-1:0] asid_q [DEPTH];
    logic [PFN_W-1:0]  pfn_q  [DEPTH];
    logic [1:0]        perm_q [DEPTH];

    logic [DEPTH-1:0]  look_m;
    logic [DEPTH-1:0]  dup_m;
    logic [IDX_W-1:0]  look_idx;

    // Per-entry comparators for the lookup and duplicate-probe ports.
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
        assign look_m[e] = valid_q[e] && (vpn_q[e] == look_vpn)
                         && (glob_q[e] || (asid_q[e] == look_asid));
        assign dup_m[e]  = valid_q[e] && (vpn_q[e] == probe_vpn)
                         && (glob_q[e] == probe_glob)
                         && (probe_glob || (asid_q[e] == probe_asid));
    end

    // Lowest-index priority selection for both compare ports.
    always_comb begin
        look_idx = '0;
        dup_idx  = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (look_m[e]) look_idx = IDX_W'(e);
            if (dup_m[e])  dup_idx  = IDX_W'(e);
        end
    end

    assign look_match = |look_m;
    assign dup_match  = |dup_m;
    assign look_pfn   = pfn_q[look_idx];
    assign look_perm  = perm_q[look_idx];
    assign look_xn    = xn_q[look_idx];
    assign lock_vec   = lock_q;

    // Valid and lock state: reset, invalidations, then writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            lock_q  <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (inv_all && !lock_q[e]) begin
                    valid_q[e] <= 1'b0;
                end
                if (inv_tag_en && valid_q[e] && !glob_q[e] && (asid_q[e] == inv_tag)) begin
                    valid_q[e] <= 1'b0;
                    lock_q[e]  <= 1'b0;
                end
                if (wr_en && (wr_idx == IDX_W'(e))) begin
                    valid_q[e] <= 1'b1;
                    lock_q[e]  <= wr_lock;
                end
            end
        end
    end

    // Payload fields: written on refill only, no reset needed.
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                vpn_q[e]  <= probe_vpn;
                asid_q[e] <= probe_asid;
                glob_q[e] <= probe_glob;
                pfn_q[e]  <= wr_pfn;
                perm_q[e] <= wr_perm;
                xn_q[e]   <= wr_xn;
            end
        end
    end

endmodule

// File: rtl/tlb_victim_sel.sv
// Victim choice: the search starts at a rotating pointer or at a free-running LFSR
// value and returns the first unlocked entry found, going circularly.
// Assumes DEPTH >= 2 and DEPTH <= 65535.
module tlb_victim_sel
    import tlb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_random,
    input  logic [DEPTH-1:0] lock_vec,
    input  logic             advance,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_ok
);

    logic [IDX_W-1:0] ptr_q;
    logic [15:0]      lfsr_q;
    logic [IDX_W-1:0] start;
    logic [31:0]      cand;

    assign start = use_random ? IDX_W'(lfsr_q % 16'(DEPTH)) : ptr_q;

    // Circular search for the first unlocked entry from the start position.
    always_comb begin
        victim_ok  = 1'b0;
        victim_idx = '0;
        cand       = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            cand = (32'(start) + 32'(k)) % 32'(DEPTH);
            if (!lock_vec[cand[IDX_W-1:0]]) begin
                victim_ok  = 1'b1;
                victim_idx = cand[IDX_W-1:0];
            end
        end
    end

    // Rotating pointer moves past each allocated victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (victim_idx == IDX_W'(DEPTH - 1)) ? '0 : victim_idx + 1'b1;
        end
    end

    // Free-running Galois LFSR for pseudo-random starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= LFSR_SEED;
        end else begin
            lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? LFSR_TAPS : 16'h0000);
        end
    end

endmodule

// File: rtl/tagged_tlb.sv
// Fully associative translation cache with address-space tags, global entries,
// lookup-time protection checks, lockable entries and selectable replacement.
// Assumes a single fixed page size of 2**PAGE_W bytes; results are registered.
module tagged_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int ASID_W = 8,
    parameter int DEPTH  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_random,
    input  logic                     lk_valid,
    input  logic [VA_W-1:0]          lk_vaddr,
    input  logic [ASID_W-1:0]        lk_asid,
    input  logic [1:0]               lk_kind,
    input  logic                     lk_user,
    input  logic                     rf_valid,
    input  logic [VA_W-PAGE_W-1:0]   rf_vpn,
    input  logic [ASID_W-1:0]        rf_asid,
    input  logic                     rf_global,
    input  logic [PA_W-PAGE_W-1:0]   rf_pfn,
    input  logic [1:0]               rf_perm,
    input  logic                     rf_xn,
    input  logic                     rf_lock,
    input  logic                     inv_all,
    input  logic                     inv_asid_en,
    input  logic [ASID_W-1:0]        inv_asid,
    output logic                     lk_done,
    output logic                     lk_hit,
    output logic                     lk_miss,
    output logic                     lk_abort,
    output logic [PA_W-1:0]          lk_paddr
);

    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PFN_W = PA_W - PAGE_W;
    localparam int IDX_W = $clog2(DEPTH);

    logic             look_match;
    logic [PFN_W-1:0] look_pfn;
    logic [1:0]       look_perm;
    logic             look_xn;
    logic             dup_match;
    logic [IDX_W-1:0] dup_idx;
    logic [DEPTH-1:0] lock_vec;
    logic [IDX_W-1:0] victim_idx;
    logic             victim_ok;
    logic             allow;
    logic             inv_any;
    logic             wr_en;
    logic             alloc;
    logic [IDX_W-1:0] wr_idx;

    assign inv_any = inv_all || inv_asid_en;
    assign wr_en   = rf_valid && !inv_any && (dup_match || victim_ok);
    assign alloc   = rf_valid && !inv_any && !dup_match && victim_ok;
    assign wr_idx  = dup_match ? dup_idx : victim_idx;

    tlb_entry_array #(
        .DEPTH (DEPTH),
        .VPN_W (VPN_W),
        .PFN_W (PFN_W),
        .ASID_W(ASID_W),
        .IDX_W (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_vpn  (lk_vaddr[VA_W-1:PAGE_W]),
        .look_asid (lk_asid),
        .look_match(look_match),
        .look_pfn  (look_pfn),
        .look_perm (look_perm),
        .look_xn   (look_xn),
        .probe_vpn (rf_vpn),
        .probe_asid(rf_asid),
        .probe_glob(rf_global),
        .dup_match (dup_match),
        .dup_idx   (dup_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_pfn    (rf_pfn),
        .wr_perm   (rf_perm),
        .wr_xn     (rf_xn),
        .wr_lock   (rf_lock),
        .inv_all   (inv_all),
        .inv_tag_en(inv_asid_en),
        .inv_tag   (inv_asid),
        .lock_vec  (lock_vec)
    );

    tlb_victim_sel #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_random(cfg_random),
        .lock_vec  (lock_vec),
        .advance   (alloc),
        .victim_idx(victim_idx),
        .victim_ok (victim_ok)
    );

    tlb_perm_check u_perm (
        .perm (perm_e'(look_perm)),
        .xn   (look_xn),
        .kind (acc_kind_e'(lk_kind)),
        .user (lk_user),
        .allow(allow)
    );

    // Register the one-cycle lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_miss  <= 1'b0;
            lk_abort <= 1'b0;
            lk_paddr <= '0;
        end else begin
            lk_done  <= lk_valid;
            lk_hit   <= lk_valid && look_match && allow;
            lk_miss  <= lk_valid && !look_match;
            lk_abort <= lk_valid && look_match && !allow;
            lk_paddr <= (lk_valid && look_match && allow)
                        ? {look_pfn, lk_vaddr[PAGE_W-1:0]} : '0;
        end
    end

endmodule

// File: rtl/tagged_tlb_chk.sv
// Property checker for tagged_tlb, attached with bind below.
// Assumes it observes the registered result outputs and the allocation signals.
module tagged_tlb_chk #(
    parameter int PA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int DEPTH  = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [PAGE_W-1:0] lk_off,
    input logic              lk_done,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_abort,
    input logic [PA_W-1:0]   lk_paddr,
    input logic              alloc,
    input logic [IDX_W-1:0]  victim_idx,
    input logic [DEPTH-1:0]  lock_vec
);

    a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> $onehot({lk_hit, lk_miss, lk_abort}));

    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_done |-> !(lk_hit || lk_miss || lk_abort));

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!lk_hit || lk_paddr[PAGE_W-1:0] == $past(lk_off)));

    a_r2_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss || lk_abort) |-> (lk_paddr == '0));

    a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !lock_vec[victim_idx]);

endmodule

bind tagged_tlb tagged_tlb_chk #(
    .PA_W  (PA_W),
    .PAGE_W(PAGE_W),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_off    (lk_vaddr[PAGE_W-1:0]),
    .lk_done   (lk_done),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_abort  (lk_abort),
    .lk_paddr  (lk_paddr),
    .alloc     (alloc),
    .victim_idx(victim_idx),
    .lock_vec  (lock_vec)
);

// File: tb/test_tagged_tlb.sv
// Self-checking bench: a behavioural model tracks entries and the rotating pointer,
// and the outputs are compared with it on every clock; directed checks follow.
module test_tagged_tlb;

    localparam int VA_W = 32, PA_W = 32, PAGE_W = 12, ASID_W = 8, DEPTH = 32;
    localparam int VPN_W = VA_W - PAGE_W, PFN_W = PA_W - PAGE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_random = 1'b0;
    logic lk_valid = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [1:0] lk_kind = 2'd1;
    logic lk_user = 1'b0;
    logic rf_valid = 1'b0;
    logic [VPN_W-1:0] rf_vpn = '0;
    logic [ASID_W-1:0] rf_asid = '0;
    logic rf_global = 1'b0;
    logic [PFN_W-1:0] rf_pfn = '0;
    logic [1:0] rf_perm = 2'd3;
    logic rf_xn = 1'b0;
    logic rf_lock = 1'b0;
    logic inv_all = 1'b0;
    logic inv_asid_en = 1'b0;
    logic [ASID_W-1:0] inv_asid = '0;
    logic lk_done, lk_hit, lk_miss, lk_abort;
    logic [PA_W-1:0] lk_paddr;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tagged_tlb #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .ASID_W(ASID_W), .DEPTH(DEPTH)
    ) i_tagged_tlb (
        .clk(clk), .rst_n(rst_n), .cfg_random(cfg_random),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_kind(lk_kind), .lk_user(lk_user),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
        .rf_global(rf_global), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
        .rf_xn(rf_xn), .rf_lock(rf_lock),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_abort(lk_abort), .lk_paddr(lk_paddr)
    );

    // ---------------- behavioural reference model ----------------
    bit              m_v    [DEPTH];
    bit              m_lock [DEPTH];
    bit              m_g    [DEPTH];
    bit              m_xn   [DEPTH];
    logic [VPN_W-1:0]  m_vpn  [DEPTH];
    logic [ASID_W-1:0] m_asid [DEPTH];
    logic [PFN_W-1:0]  m_pfn  [DEPTH];
    logic [1:0]        m_perm [DEPTH];
    int m_ptr;
    bit e_done, e_hit, e_miss, e_abort;
    logic [PA_W-1:0] e_paddr;
    int f_idx, slot;

    function automatic bit allowed(logic [1:0] p, bit xn, logic [1:0] k, bit u);
        bit ok;
        ok = 1'b1;
        if (p == 2'd0) ok = 1'b0;
        if (p == 2'd1 && u) ok = 1'b0;
        if (p == 2'd2 && u && k == 2'd2) ok = 1'b0;
        if (k == 2'd0 && xn) ok = 1'b0;
        return ok;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_lock[i] = 0; end
            m_ptr = 0;
            e_done = 0; e_hit = 0; e_miss = 0; e_abort = 0; e_paddr = '0;
        end else begin
            // lookup against the contents before this edge
            f_idx = -1;
            for (int i = DEPTH - 1; i >= 0; i--)
                if (m_v[i] && m_vpn[i] == lk_vaddr[VA_W-1:PAGE_W] && (m_g[i] || m_asid[i] == lk_asid))
                    f_idx = i;
            e_done = lk_valid; e_hit = 0; e_miss = 0; e_abort = 0; e_paddr = '0;
            if (lk_valid) begin
                if (f_idx < 0) e_miss = 1;
                else if (allowed(m_perm[f_idx], m_xn[f_idx], lk_kind, lk_user)) begin
                    e_hit = 1; e_paddr = {m_pfn[f_idx], lk_vaddr[PAGE_W-1:0]};
                end else e_abort = 1;
            end
            // maintenance
            for (int i = 0; i < DEPTH; i++) begin
                if (inv_all && !m_lock[i]) m_v[i] = 0;
                if (inv_asid_en && m_v[i] && !m_g[i] && m_asid[i] == inv_asid) begin
                    m_v[i] = 0; m_lock[i] = 0;
                end
            end
            // refill
            if (rf_valid && !inv_all && !inv_asid_en) begin
                slot = -1;
                for (int i = DEPTH - 1; i >= 0; i--)
                    if (m_v[i] && m_vpn[i] == rf_vpn && m_g[i] == rf_global && (rf_global || m_asid[i] == rf_asid))
                        slot = i;
                if (slot < 0) begin
                    for (int k = DEPTH - 1; k >= 0; k--)
                        if (!m_lock[(m_ptr + k) % DEPTH]) slot = (m_ptr + k) % DEPTH;
                    if (slot >= 0) m_ptr = (slot + 1) % DEPTH;
                end
                if (slot >= 0) begin
                    m_v[slot] = 1; m_lock[slot] = rf_lock; m_g[slot] = rf_global;
                    m_xn[slot] = rf_xn; m_vpn[slot] = rf_vpn; m_asid[slot] = rf_asid;
                    m_pfn[slot] = rf_pfn; m_perm[slot] = rf_perm;
                end
            end
        end
    end

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check({lk_done, lk_hit, lk_miss, lk_abort} == {e_done, e_hit, e_miss, e_abort},
                  "R1", "outcome flags", 64'({lk_done, lk_hit, lk_miss, lk_abort}),
                  64'({e_done, e_hit, e_miss, e_abort}));
            check(lk_paddr == e_paddr, "R2", "paddr", 64'(lk_paddr), 64'(e_paddr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic refill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                          input bit g, input logic [PFN_W-1:0] pfn, input logic [1:0] perm,
                          input bit xn, input bit lock);
        @(negedge clk);
        rf_valid = 1; rf_vpn = vpn; rf_asid = asid; rf_global = g;
        rf_pfn = pfn; rf_perm = perm; rf_xn = xn; rf_lock = lock;
        @(negedge clk);
        rf_valid = 0;
    endtask

    task automatic look(input logic [VPN_W-1:0] vpn, input logic [PAGE_W-1:0] off,
                        input logic [ASID_W-1:0] asid, input logic [1:0] kind, input bit user,
                        output logic [3:0] res, output logic [PA_W-1:0] pa);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_asid = asid; lk_kind = kind; lk_user = user;
        @(negedge clk);
        lk_valid = 0;
        res = {lk_done, lk_hit, lk_miss, lk_abort};
        pa = lk_paddr;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    localparam logic [3:0] HIT = 4'b1100, MISS = 4'b1010, ABT = 4'b1001;

    task automatic expect_res(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                              input logic [1:0] kind, input bit user, input logic [3:0] want,
                              input string req);
        logic [3:0] r;
        logic [PA_W-1:0] p;
        look(vpn, 12'h0A5, asid, kind, user, r, p);
        check(r == want, req, "lookup outcome", 64'(r), 64'(want));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [3:0] r;
        logic [PA_W-1:0] p;
        int alive;

        do_reset();
        cmp_en = 1;
        // R12: reset state
        check({lk_done, lk_hit, lk_miss, lk_abort} == 4'b0 && lk_paddr == '0, "R12",
              "outputs after reset", 64'({lk_done, lk_hit, lk_miss, lk_abort}), 64'd0);
        expect_res(20'h00100, 8'd1, 2'd1, 0, MISS, "R12");

        // R2 translation and R3 tags
        refill(20'h00100, 8'd1, 0, 20'h00ABC, 2'd3, 0, 0);
        look(20'h00100, 12'h345, 8'd1, 2'd1, 1, r, p);
        check(r == HIT && p == 32'h00ABC345, "R2", "hit address", 64'(p), 64'h00ABC345);
        expect_res(20'h00100, 8'd2, 2'd1, 1, MISS, "R3");
        refill(20'h00200, 8'd5, 1, 20'h00222, 2'd3, 0, 0);
        expect_res(20'h00200, 8'd9, 2'd1, 1, HIT, "R3");

        // R4 permissions
        refill(20'h00300, 8'd1, 0, 20'h00300, 2'd1, 0, 0);
        refill(20'h00301, 8'd1, 0, 20'h00301, 2'd2, 0, 0);
        refill(20'h00302, 8'd1, 0, 20'h00302, 2'd0, 0, 0);
        refill(20'h00303, 8'd1, 0, 20'h00303, 2'd3, 1, 0);
        expect_res(20'h00300, 8'd1, 2'd1, 1, ABT, "R4");
        expect_res(20'h00300, 8'd1, 2'd1, 0, HIT, "R4");
        expect_res(20'h00301, 8'd1, 2'd2, 1, ABT, "R4");
        expect_res(20'h00301, 8'd1, 2'd1, 1, HIT, "R4");
        expect_res(20'h00301, 8'd1, 2'd2, 0, HIT, "R4");
        expect_res(20'h00302, 8'd1, 2'd1, 0, ABT, "R4");
        expect_res(20'h00303, 8'd1, 2'd0, 0, ABT, "R4");
        expect_res(20'h00303, 8'd1, 2'd1, 1, HIT, "R4");

        // R8 duplicate refill overwrites in place
        refill(20'h00100, 8'd1, 0, 20'h00777, 2'd3, 0, 0);
        look(20'h00100, 12'h001, 8'd1, 2'd1, 0, r, p);
        check(r == HIT && p == 32'h00777001, "R8", "rewritten frame", 64'(p), 64'h00777001);

        // R5 rotation with R7 lock skipping: locked entry in slot 6, pointer then 7
        refill(20'h00400, 8'd0, 1, 20'h00400, 2'd3, 0, 1);
        for (int i = 0; i < 40; i++)
            refill(VPN_W'(20'h00500 + i), 8'd3, 0, PFN_W'(20'h10000 + i), 2'd3, 0, 0);
        expect_res(20'h00500, 8'd3, 2'd1, 0, MISS, "R5");
        expect_res(20'h00510, 8'd3, 2'd1, 0, HIT, "R5");
        expect_res(20'h0051F, 8'd3, 2'd1, 0, HIT, "R5");
        expect_res(20'h00400, 8'd3, 2'd1, 0, HIT, "R7");

        // R9 invalidate by tag
        refill(20'h00600, 8'd3, 0, 20'h00600, 2'd3, 0, 1);
        refill(20'h00650, 8'd4, 0, 20'h00650, 2'd3, 0, 0);
        @(negedge clk); inv_asid_en = 1; inv_asid = 8'd3;
        @(negedge clk); inv_asid_en = 0;
        expect_res(20'h00510, 8'd3, 2'd1, 0, MISS, "R9");
        expect_res(20'h00600, 8'd3, 2'd1, 0, MISS, "R9");
        expect_res(20'h00400, 8'd3, 2'd1, 0, HIT, "R9");
        expect_res(20'h00650, 8'd4, 2'd1, 0, HIT, "R9");

        // R11 refill during invalidate is dropped; lookup sees old contents
        @(negedge clk);
        inv_asid_en = 1; inv_asid = 8'd7;
        rf_valid = 1; rf_vpn = 20'h00700; rf_asid = 8'd1; rf_global = 0; rf_lock = 0;
        @(negedge clk); inv_asid_en = 0; rf_valid = 0;
        expect_res(20'h00700, 8'd1, 2'd1, 0, MISS, "R11");
        @(negedge clk);
        rf_valid = 1; rf_vpn = 20'h00800; rf_asid = 8'd1; rf_global = 0; rf_pfn = 20'h00888;
        lk_valid = 1; lk_vaddr = {20'h00800, 12'h000}; lk_asid = 8'd1; lk_kind = 2'd1; lk_user = 0;
        @(negedge clk); rf_valid = 0; lk_valid = 0;
        check(lk_miss, "R11", "same-cycle lookup", 64'(lk_miss), 64'd1);
        expect_res(20'h00800, 8'd1, 2'd1, 0, HIT, "R11");

        // R10 invalidate all keeps locked entries
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
        expect_res(20'h00400, 8'd1, 2'd1, 0, HIT, "R10");
        expect_res(20'h00800, 8'd1, 2'd1, 0, MISS, "R10");

        // R7 every entry locked: new refill is discarded
        for (int i = 0; i < DEPTH - 1; i++)
            refill(VPN_W'(20'h00900 + i), 8'd2, 0, PFN_W'(20'h20000 + i), 2'd3, 0, 1);
        refill(20'h00A00, 8'd2, 0, 20'h00AAA, 2'd3, 0, 0);
        expect_res(20'h00A00, 8'd2, 2'd1, 0, MISS, "R7");
        expect_res(20'h00900, 8'd2, 2'd1, 0, HIT, "R7");

        // R6 random replacement (model cannot predict victims)
        cmp_en = 0;
        do_reset();
        cfg_random = 1;
        refill(20'h00B00, 8'd0, 1, 20'h00B00, 2'd3, 0, 1);
        for (int i = 0; i < DEPTH - 1; i++)
            refill(VPN_W'(20'h00C00 + i), 8'd6, 0, PFN_W'(20'h30000 + i), 2'd3, 0, 0);
        for (int i = 0; i < DEPTH - 1; i++)
            refill(VPN_W'(20'h00D00 + i), 8'd6, 0, PFN_W'(20'h40000 + i), 2'd3, 0, 0);
        alive = 0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            look(VPN_W'(20'h00C00 + i), 12'h0, 8'd6, 2'd1, 0, r, p);
            if (r == HIT) alive++;
        end
        check(alive > 0, "R6", "older entries surviving", 64'(alive), 64'd1);
        expect_res(20'h00D1E, 8'd6, 2'd1, 0, HIT, "R6");
        expect_res(20'h00B00, 8'd6, 2'd1, 0, HIT, "R7");

        finished = 1;
        summary();
    end

endmodule